// File: doc/BRIEF.md
# SPI Interrupt Status and Receive Timeout

This block collects the interrupt sources of an SPI controller. It watches the receive FIFO fill level, the FIFO pop strobe and the frame-complete strobe from the shifter, and the transmit FIFO level. It also accepts event pulses from a DMA engine. Each source sets one sticky bit in a raw status word. The interrupt line is the OR of every raw bit whose enable bit is also set.

Three sources are derived inside the block. A receive overflow happens when a frame completes while the receive FIFO is full. In that case the block tells the FIFO to replace its most recently stored entry with the new frame, and it does not issue a normal push. A receive idle timeout counts clock cycles while the FIFO holds data and nothing is pushed or popped. The threshold flags compare each FIFO level against a programmable limit. Software reaches the block through a small word-addressed port: enable at address 0, raw status at address 1 and write-one-to-clear at address 2. Address 3 reads as zero.

Top module: `spi_irq_hub`

## Requirements
- R1: After reset the enable word and the raw status word read 0, `irq` is low, and no FIFO write strobe is driven while `rx_frame_done` is low.
- R2: Both words use bit 0 for overflow, bit 1 for timeout, bit 2 for receive threshold, bit 3 for transmit threshold, bit 4 for DMA half and bit 5 for DMA complete. Bits 31:6 always read 0. The enable word at address 0 is read/write. `irq` is high exactly when some raw bit and its enable bit are both 1.
- R3: A raw bit sets on its event in the cycle after the event, whether its enable bit is set or not.
- R4: The timeout bit (bit 1) sets after the receive level has been non-zero for 32 consecutive cycles with no pop and no frame completion. A pop or a frame completion restarts the count. An empty FIFO never raises it.
- R5: The timeout bit is raised at most once per idle period. After software clears it, it stays clear until a pop or a push starts a new period.
- R6: A raw bit stays set until a write to address 2 has a 1 in that bit position. Address 2 reads as 0.
- R7: When a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: If `rx_frame_done` is high while `rx_level` equals the FIFO depth, then `rx_overwrite` is high, `rx_push` is low and bit 0 sets. If `rx_frame_done` is high below full, then `rx_push` is high and `rx_overwrite` is low.
- R9: Bit 2 sets while `rx_level >= rx_thr`. Bit 3 sets while `tx_level <= tx_thr`.
- R10: A one-cycle pulse on `dma_half` sets bit 4 and a pulse on `dma_done` sets bit 5. With the DMA parameter off, both bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_frame_done | input | 1 | A frame has been completely received |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_thr | input | LVL_W | Receive threshold |
| tx_thr | input | LVL_W | Transmit threshold |
| dma_half | input | 1 | DMA half-transfer event pulse |
| dma_done | input | 1 | DMA transfer-complete event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_push | output | 1 | Store the incoming frame as a new FIFO entry |
| rx_overwrite | output | 1 | Replace the newest FIFO entry with the incoming frame |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-formed environment. `rx_level` never exceeds the FIFO depth, `rx_pop` only arrives while the level is non-zero, and each DMA event lasts a single cycle. The set-wins and sticky-bit properties rely on clears arriving only through register writes. The directed stimulus keeps to these limits. It drives levels within 0 to the depth and pulses every strobe for exactly one cycle on the falling edge. Before each scenario it parks the thresholds and levels where no unintended source fires.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC   = 6;
  localparam int B_OVF     = 0;
  localparam int B_TMO     = 1;
  localparam int B_RXTH    = 2;
  localparam int B_TXTH    = 3;
  localparam int B_DHALF   = 4;
  localparam int B_DDONE   = 5;

  localparam logic [1:0] A_ENABLE = 2'd0;
  localparam logic [1:0] A_RAW    = 2'd1;
  localparam logic [1:0] A_CLEAR  = 2'd2;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/spi_irq_timeout.sv
module spi_irq_timeout #(
  parameter int LVL_W     = 4,
  parameter int TO_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_pop,
  input  logic             rx_frame_done,
  output logic             to_evt
);
  localparam int CNT_W = (TO_CYCLES > 1) ? $clog2(TO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fired_q, fired_d;
  logic             restart, cnt_en, fired_en;

  always_comb begin
    restart  = (rx_level == '0) | rx_pop | rx_frame_done;
    to_evt   = !restart && !fired_q && (cnt_q == LAST);
    cnt_en   = restart | (!fired_q && (cnt_q != LAST));
    cnt_d    = restart ? '0 : cnt_q + 1'b1;
    fired_en = restart | to_evt;
    fired_d  = !restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (fired_en) fired_q <= fired_d;
    end
  end

  // R5: one event per idle period
  assert_single_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> !to_evt);
  // R4: an event needs a non-empty FIFO on the previous cycle as well
  assert_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |-> ($past(rx_level) != '0));
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t ev,
  input  src_vec_t clr,
  output src_vec_t raw
);
  src_vec_t raw_d, raw_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign raw_d[i]  = ev[i] | (raw[i] & ~clr[i]);
    assign raw_en[i] = ev[i] | clr[i];

    // R6: sticky until cleared
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[i] && !clr[i]) |=> raw[i]);
    // R7: set beats clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> raw[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (raw_en[i]) raw[i] <= raw_d[i];
    end
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  src_vec_t    raw,
  output src_vec_t    en,
  output src_vec_t    clr,
  output logic [31:0] reg_rdata
);
  logic en_we;

  always_comb begin
    en_we     = reg_we && (reg_addr == A_ENABLE);
    clr       = (reg_we && (reg_addr == A_CLEAR)) ? reg_wdata[NUM_SRC-1:0] : '0;
    reg_rdata = '0;
    case (reg_addr)
      A_ENABLE: reg_rdata[NUM_SRC-1:0] = en;
      A_RAW:    reg_rdata[NUM_SRC-1:0] = raw;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= reg_wdata[NUM_SRC-1:0];
  end

  // R2: upper bits never carry data
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:NUM_SRC] == '0);
  // R6: the clear word is write-only
  assert_clear_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CLEAR) |-> (reg_rdata == '0));
endmodule

// File: rtl/spi_irq_hub.sv
module spi_irq_hub
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TO_CYCLES  = 32,
  parameter bit HAS_DMA    = 1'b1,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_pop,
  input  logic             rx_frame_done,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic             dma_half,
  input  logic             dma_done,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             rx_push,
  output logic             rx_overwrite,
  output logic             irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  src_vec_t ev, raw, en, clr;
  logic     rx_full, to_evt;

  assign rx_full      = (rx_level == FULL_LVL);
  assign rx_push      = rx_frame_done & ~rx_full;
  assign rx_overwrite = rx_frame_done &  rx_full;

  assign ev[B_OVF]  = rx_overwrite;
  assign ev[B_TMO]  = to_evt;
  assign ev[B_RXTH] = (rx_level >= rx_thr);
  assign ev[B_TXTH] = (tx_level <= tx_thr);

  if (HAS_DMA) begin : g_dma
    assign ev[B_DHALF] = dma_half;
    assign ev[B_DDONE] = dma_done;
  end else begin : g_no_dma
    logic unused_dma;
    assign unused_dma  = dma_half ^ dma_done;
    assign ev[B_DHALF] = 1'b0;
    assign ev[B_DDONE] = 1'b0;
    // R10: DMA bits are tied off
    assert_dma_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      raw[B_DDONE:B_DHALF] == '0);
  end

  assign irq = |(raw & en);

  spi_irq_timeout #(.LVL_W(LVL_W), .TO_CYCLES(TO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_pop(rx_pop),
    .rx_frame_done(rx_frame_done), .to_evt(to_evt));

  spi_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr), .raw(raw));

  spi_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .raw(raw), .en(en), .clr(clr), .reg_rdata(reg_rdata));

  // R8: a frame goes to exactly one of push or overwrite
  assert_one_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push && rx_overwrite));
  // R8: an overwrite leaves the overflow flag set
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overwrite |=> raw[B_OVF]);
  // R2: an interrupt needs at least one enable
  assert_irq_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(en) > 0));
endmodule

// File: tb/sim_spi_irq_hub.sv
module sim_spi_irq_hub;
  timeunit 1ns; timeprecision 1ps;

  localparam int DEPTH = 8;
  localparam int LW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] rx_level, tx_level, rx_thr, tx_thr;
  logic          rx_pop, rx_frame_done, dma_half, dma_done, reg_we;
  logic [1:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          rx_push, rx_overwrite, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_irq_hub #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_pop(rx_pop),
    .rx_frame_done(rx_frame_done), .tx_level(tx_level), .rx_thr(rx_thr),
    .tx_thr(tx_thr), .dma_half(dma_half), .dma_done(dma_done),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_overwrite(rx_overwrite),
    .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic park();
    rx_level = '0; tx_level = 4'd8; rx_thr = 4'd6; tx_thr = 4'd2;
    rx_pop = 0; rx_frame_done = 0; dma_half = 0; dma_done = 0;
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h3F);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 enable", d, 32'h0);
    rd(2'd1, d); check("R1 raw", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 push", {30'b0, rx_push, rx_overwrite}, 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFEA);
    rd(2'd0, d); check("R2 enable upper zero", d, 32'h2A);
    rd(2'd3, d); check("R2 addr3 zero", d, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    park();
    @(negedge clk); dma_half = 1;
    @(negedge clk); dma_half = 0;
    rd(2'd1, d); check("R3 R10 half set while disabled", d, 32'h10);
    check("R3 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h10);
    check("R2 irq on enable", {31'b0, irq}, 32'h1);
    rd(2'd2, d); check("R6 clear reads zero", d, 32'h0);
    wr(2'd2, 32'h10);
    rd(2'd1, d); check("R6 cleared", d, 32'h0);
    check("R2 irq drops", {31'b0, irq}, 32'h0);
    @(negedge clk); dma_done = 1;
    @(negedge clk); dma_done = 0;
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R6 R10 done sticky", d, 32'h20);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    park();
    @(negedge clk);
    dma_done = 1; reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'h20;
    @(negedge clk);
    dma_done = 0; reg_we = 0; reg_wdata = 0;
    rd(2'd1, d); check("R7 set wins", d, 32'h20);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    park();
    rx_thr = 4'd15;
    @(negedge clk); rx_level = 4'd5; rx_frame_done = 1; #1;
    check("R8 push below full", {30'b0, rx_push, rx_overwrite}, 32'h2);
    @(negedge clk); rx_frame_done = 0;
    rd(2'd1, d); check("R8 no flag below full", d[0], 32'h0);
    rx_level = 4'd8; rx_frame_done = 1; #1;
    check("R8 overwrite when full", {30'b0, rx_push, rx_overwrite}, 32'h1);
    @(negedge clk); rx_frame_done = 0; rx_level = 0;
    rd(2'd1, d); check("R8 overflow flag", d[0], 32'h1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    park();
    rx_level = 4'd1; rx_frame_done = 1;
    @(negedge clk); rx_frame_done = 0;
    repeat (31) @(negedge clk);
    rd(2'd1, d); check("R4 not yet at 31", d[1], 32'h0);
    @(negedge clk);
    rd(2'd1, d); check("R4 set at 32", d[1], 32'h1);
    wr(2'd2, 32'h2);
    repeat (40) @(negedge clk);
    rd(2'd1, d); check("R5 once per idle", d[1], 32'h0);
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    repeat (20) @(negedge clk);
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    repeat (31) @(negedge clk);
    rd(2'd1, d); check("R4 pop restarts", d[1], 32'h0);
    @(negedge clk);
    rd(2'd1, d); check("R4 refire after pop", d[1], 32'h1);
    rx_level = 0;
    wr(2'd2, 32'h2);
    repeat (40) @(negedge clk);
    rd(2'd1, d); check("R4 empty never fires", d[1], 32'h0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    park();
    rx_level = 4'd5; tx_level = 4'd3;
    repeat (2) @(negedge clk);
    rd(2'd1, d); check("R9 outside thresholds", d[3:2], 32'h0);
    rx_level = 4'd6;
    @(negedge clk);
    rd(2'd1, d); check("R9 rx reaches", d[3:2], 32'h1);
    tx_level = 4'd2;
    @(negedge clk);
    rd(2'd1, d); check("R9 tx falls to", d[3:2], 32'h3);
    rx_level = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    rx_level = 0; tx_level = 4'd8; rx_thr = 4'd6; tx_thr = 4'd2;
    rx_pop = 0; rx_frame_done = 0; dma_half = 0; dma_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_dma();
    t_set_wins();
    t_overflow();
    t_timeout();
    t_thresh();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule